// File: doc/BRIEF.md
# Clocked Synchronous Serial Byte Transmitter

This block sends bytes over a clocked synchronous serial link. Software writes a byte into a holding register. When the shifter is free and no receiver error is pending, the byte moves into the shift register, the holding register is marked empty again, and the bits go out one per serial clock period, least significant bit first. Because of the two stages, software can write the next byte while the current one is still shifting out. Frames then follow one another with no gap on the line.

The serial clock has two sources, chosen at run time. In internal mode a divider of the system clock generates the clock and drives it on the clock output pin. There are exactly eight pulses per frame, and the data changes on the falling edges so that a receiver can sample on the rising edges. In external mode the incoming clock passes through a synchronizer, and the data advances on its falling edges. While the block is idle, the clock pin rests high.

One moment decides what happens at a frame boundary: the cycle in which the last bit of a frame is placed on the line. If a byte is waiting at that moment, it is loaded and its first bit follows directly after the last bit. If no byte is waiting, the end flag is set, the data line keeps the level of the last bit, and the clock stops high. Two level interrupt requests, each with its own enable, report an empty holding register and the end of transmission.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset, `hold_empty` = 1, `tx_done` = 1, `sck_o` = 1 and `txd` = 1.
- R2: A cycle with `wr_en` = 1 stores `wr_data`, and from the next cycle on both `hold_empty` and `tx_done` read 0.
- R3: While the shifter is idle, `hold_empty` = 0 and `rx_err` = 0 together cause a copy into the shift register at the next clock edge. The copy sets `hold_empty` back to 1.
- R4: `irq_empty` equals `ie_empty & hold_empty` in every cycle.
- R5: Each frame sends `DATA_W` bits, bit 0 first. `txd` changes only when the serial clock falls, and it is stable when the serial clock rises.
- R6: In internal mode (`ext_sck_sel` = 0) each frame produces exactly `DATA_W` (8) rising edges on `sck_o`. Each clock phase lasts `DIV_HALF` system cycles.
- R7: A byte that is waiting when bit 7 goes onto the line is loaded at that moment. Its bit 0 follows with no idle time: consecutive `sck_o` rising edges keep a spacing of 2*`DIV_HALF` cycles across the frame boundary, and `tx_done` stays 0.
- R8: If nothing is waiting when bit 7 goes onto the line, `tx_done` is set to 1 and `txd` keeps the bit-7 level after the frame.
- R9: `sck_o` is 1 whenever the block is idle, and at all times in external mode.
- R10: `irq_done` equals `ie_done & tx_done` in every cycle.
- R11: While any bit of `rx_err` (bit 2 overrun, bit 1 framing, bit 0 parity) is 1, no byte is loaded and `hold_empty` stays 0. A bit-7 check made under an error counts as "nothing waiting".
- R12: In external mode (`ext_sck_sel` = 1), `sck_i` is synchronized through `SYNC_STAGES` flops. Each falling edge of `sck_i` advances `txd` by one bit, and the data is valid on the next rising edge of `sck_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| ie_empty | input | 1 | Enable for the holding-register-empty interrupt |
| ie_done | input | 1 | Enable for the transmit-end interrupt |
| ext_sck_sel | input | 1 | 1 = external serial clock, 0 = internal divider |
| sck_i | input | 1 | External serial clock |
| rx_err | input | 3 | Receiver error inputs {overrun, framing, parity} |
| sck_o | output | 1 | Serial clock output, parked high |
| txd | output | 1 | Serial data output |
| hold_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmission-ended flag |
| irq_empty | output | 1 | Holding-register-empty interrupt request |
| irq_done | output | 1 | Transmit-end interrupt request |

## Verification
The hardest case to reach is the seamless frame boundary. It needs the next byte to be written after the previous one has been copied, but before bit 7 of the running frame appears. The driver therefore writes each byte as soon as `hold_empty` rises. This puts three bytes into one unbroken burst. The monitor records every rising edge of `sck_o`, so the bench can check the spacing across both boundaries. The second hard case is a bit-7 check made while a receiver error is pending. The bench raises an error, writes a byte, and watches that nothing leaves the line until the error clears.

// File: rtl/sst_pkg.sv
package sst_pkg;

   // serial clock events seen by the shifter, one system cycle wide
   typedef struct packed {
      logic fall;
      logic rise;
   } sck_evt_t;

   // receiver error input bit positions
   localparam int unsigned ERR_OVR = 2;
   localparam int unsigned ERR_FRM = 1;
   localparam int unsigned ERR_PAR = 0;
   localparam int unsigned ERR_W   = 3;

endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen
   import sst_pkg::*;
#(
   parameter int unsigned DIV_HALF    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     ext_sel,
   input  logic     sck_in,
   output sck_evt_t evt,
   output logic     sck_int
);

   localparam int unsigned CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DIV_HALF < 1) begin : g_bad_div
      $error("DIV_HALF must be at least 1");
   end

   // external clock path: synchronizer chain plus edge detector
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_prev;
   logic                   ext_fall, ext_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q    <= '1;
         sync_prev <= 1'b1;
      end else begin
         sync_q    <= {sync_q[SYNC_STAGES-2:0], sck_in};
         sync_prev <= sync_q[SYNC_STAGES-1];
      end
   end

   assign ext_fall = sync_prev & ~sync_q[SYNC_STAGES-1];
   assign ext_rise = ~sync_prev & sync_q[SYNC_STAGES-1];

   // internal clock path: phase tick from a divider
   logic tick;

   if (DIV_HALF == 1) begin : g_div_bypass
      assign tick = run;
   end else begin : g_div_count
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || !run)                   cnt <= '0;
         else if (cnt == CNT_W'(DIV_HALF - 1)) cnt <= '0;
         else                                  cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == CNT_W'(DIV_HALF - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) sck_int <= 1'b1;
      else if (tick)      sck_int <= ~sck_int;
   end

   always_comb begin
      if (ext_sel) begin
         evt.fall = ext_fall;
         evt.rise = ext_rise;
      end else begin
         evt.fall = tick &  sck_int;
         evt.rise = tick & ~sck_int;
      end
   end

endmodule

// File: rtl/sst_holdreg.sv
module sst_holdreg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   input  logic              end_set,
   input  logic              ie_empty,
   input  logic              ie_done,
   output logic [DATA_W-1:0] hold_q,
   output logic              empty,
   output logic              done,
   output logic              irq_empty,
   output logic              irq_done
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         empty  <= 1'b1;
         done   <= 1'b1;
      end else begin
         if (wr_en) hold_q <= wr_data;
         // a write wins over a copy in the same cycle: it is a fresh byte
         if (wr_en)     empty <= 1'b0;
         else if (load) empty <= 1'b1;
         if (wr_en)        done <= 1'b0;
         else if (end_set) done <= 1'b1;
      end
   end

   assign irq_empty = ie_empty & empty;
   assign irq_done  = ie_done  & done;

endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
   import sst_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sck_evt_t          evt,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              load_ok,
   output logic              load,
   output logic              end_set,
   output logic              busy,
   output logic              txd
);

   localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] sr;
   logic [IDX_W-1:0]  idx;
   logic              last;
   logic              put_bit, at_last;

   assign put_bit = busy && evt.fall && !last;
   assign at_last = put_bit && (idx == LAST_IDX);
   assign load    = (!busy && load_ok) || (at_last && load_ok);
   assign end_set = at_last && !load_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr   <= '0;
         idx  <= '0;
         last <= 1'b0;
         busy <= 1'b0;
         txd  <= 1'b1;
      end else if (!busy) begin
         if (load_ok) begin
            sr   <= hold_q;
            idx  <= '0;
            last <= 1'b0;
            busy <= 1'b1;
         end
      end else begin
         if (put_bit) begin
            txd <= sr[0];
            if (idx == LAST_IDX) begin
               idx <= '0;
               if (load_ok) sr <= hold_q;
               else begin
                  sr   <= sr >> 1;
                  last <= 1'b1;
               end
            end else begin
               idx <= idx + 1'b1;
               sr  <= sr >> 1;
            end
         end
         if (evt.rise && last) busy <= 1'b0;
      end
   end

endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
   import sst_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DIV_HALF    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ie_empty,
   input  logic              ie_done,
   input  logic              ext_sck_sel,
   input  logic              sck_i,
   input  logic [2:0]        rx_err,
   output logic              sck_o,
   output logic              txd,
   output logic              hold_empty,
   output logic              tx_done,
   output logic              irq_empty,
   output logic              irq_done
);

   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   sck_evt_t          evt;
   logic              sck_int;
   logic              busy, load, end_set, load_ok;
   logic [DATA_W-1:0] hold_q;

   assign load_ok = !hold_empty && !(|rx_err);

   sst_clkgen #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy && !ext_sck_sel),
      .ext_sel (ext_sck_sel),
      .sck_in  (sck_i),
      .evt     (evt),
      .sck_int (sck_int)
   );

   sst_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .load      (load),
      .end_set   (end_set),
      .ie_empty  (ie_empty),
      .ie_done   (ie_done),
      .hold_q    (hold_q),
      .empty     (hold_empty),
      .done      (tx_done),
      .irq_empty (irq_empty),
      .irq_done  (irq_done)
   );

   sst_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .hold_q  (hold_q),
      .load_ok (load_ok),
      .load    (load),
      .end_set (end_set),
      .busy    (busy),
      .txd     (txd)
   );

   assign sck_o = ext_sck_sel ? 1'b1 : sck_int;

endmodule

// File: rtl/sst_checker.sv
module sst_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       ext_sck_sel,
   input logic [2:0] rx_err,
   input logic       busy,
   input logic       sck_o,
   input logic       txd,
   input logic       hold_empty,
   input logic       tx_done
);

   // R2: a write clears both flags for the following cycle
   p_wr_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!hold_empty && !tx_done));

   // R9: clock line parked high whenever the shifter is idle
   p_sck_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy || ext_sck_sel) |-> sck_o);

   // R8: the data line holds its level while idle
   p_txd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(txd));

   // R11: a pending receiver error keeps an idle shifter idle
   p_err_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (|rx_err)) |=> !busy);

   // R3: a copy from idle needs a waiting byte and no error
   p_start_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (hold_empty || (|rx_err))) |=> !busy);

endmodule

bind sync_ser_tx sst_checker u_sst_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .ext_sck_sel (ext_sck_sel),
   .rx_err      (rx_err),
   .busy        (busy),
   .sck_o       (sck_o),
   .txd         (txd),
   .hold_empty  (hold_empty),
   .tx_done     (tx_done)
);

// File: tb/test_sync_ser_tx.sv
`timescale 1ns/1ps
module test_sync_ser_tx;

   localparam int DW   = 8;
   localparam int DIVH = 4;
   localparam int EXTH = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          ie_empty = 1'b0, ie_done = 1'b0;
   logic          ext_sck_sel = 1'b0, sck_i = 1'b1;
   logic [2:0]    rx_err = '0;
   logic          sck_o, txd, hold_empty, tx_done, irq_empty, irq_done;

   always #2.5 clk = ~clk;

   sync_ser_tx #(.DATA_W(DW), .DIV_HALF(DIVH), .SYNC_STAGES(2)) i_sync_ser_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ie_empty(ie_empty), .ie_done(ie_done), .ext_sck_sel(ext_sck_sel),
      .sck_i(sck_i), .rx_err(rx_err), .sck_o(sck_o), .txd(txd),
      .hold_empty(hold_empty), .tx_done(tx_done),
      .irq_empty(irq_empty), .irq_done(irq_done));

   int n_cmp = 0, n_bad = 0;
   int cyc = 0;
   bit done_flag = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // scoreboard: expected bytes in write order
   logic [DW-1:0] exp_q[$];
   int            rise_times[$];
   int            rise_cnt = 0;
   int            nb = 0;
   logic [DW-1:0] rx_sh = '0;
   logic          mon_prev = 1'b1;

   always @(negedge clk) begin
      logic mclk;
      if (rst_n) begin
         mclk = ext_sck_sel ? sck_i : sck_o;
         if (mclk && !mon_prev) begin
            rise_cnt++;
            rise_times.push_back(cyc);
            rx_sh = {txd, rx_sh[DW-1:1]};
            nb++;
            if (nb == DW) begin
               nb = 0;
               if (exp_q.size() == 0) chk(1'b0, "R5 unexpected frame", rx_sh, 0);
               else begin
                  logic [DW-1:0] e;
                  e = exp_q.pop_front();
                  chk(rx_sh == e, "R5 frame data LSB first", rx_sh, e);
               end
            end
         end
         mon_prev = mclk;
      end
   end

   task automatic write_byte(input logic [DW-1:0] b);
      @(negedge clk);
      wr_en = 1'b1; wr_data = b;
      exp_q.push_back(b);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_empty();
      for (int i = 0; i < 2000 && !hold_empty; i++) @(negedge clk);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 4000 && !tx_done; i++) @(negedge clk);
      repeat (2*DIVH + 4) @(negedge clk);
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1 sck_i = 1'b0;
         repeat (EXTH) @(posedge clk);
         #1 sck_i = 1'b1;
         repeat (EXTH) @(posedge clk);
      end
   endtask

   initial begin
      int r0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(hold_empty == 1'b1, "R1 empty after reset", hold_empty, 1);
      chk(tx_done == 1'b1,    "R1 end flag after reset", tx_done, 1);
      chk(sck_o == 1'b1,      "R1 clock high after reset", sck_o, 1);
      chk(txd == 1'b1,        "R1 data high after reset", txd, 1);
      // R4 / R10 interrupt gating
      chk(irq_empty == 1'b0, "R4 irq masked", irq_empty, 0);
      ie_empty = 1'b1; ie_done = 1'b1;
      @(negedge clk);
      chk(irq_empty == 1'b1, "R4 irq with empty", irq_empty, 1);
      chk(irq_done == 1'b1,  "R10 irq with end flag", irq_done, 1);

      // single frame, internal clock
      rise_cnt = 0;
      @(negedge clk); wr_en = 1'b1; wr_data = 8'hA6; exp_q.push_back(8'hA6);
      @(negedge clk); wr_en = 1'b0;
      chk(hold_empty == 1'b0, "R2 empty cleared by write", hold_empty, 0);
      chk(tx_done == 1'b0,    "R2 end cleared by write", tx_done, 0);
      chk(irq_empty == 1'b0,  "R4 irq drops with byte waiting", irq_empty, 0);
      @(negedge clk);
      chk(hold_empty == 1'b1, "R3 copy sets empty", hold_empty, 1);
      chk(irq_empty == 1'b1,  "R4 irq after copy", irq_empty, 1);
      chk(irq_done == 1'b0,   "R10 irq off while sending", irq_done, 0);
      wait_done();
      chk(rise_cnt == DW,     "R6 pulses per frame", rise_cnt, DW);
      chk(tx_done == 1'b1,    "R8 end flag set", tx_done, 1);
      chk(irq_done == 1'b1,   "R10 irq at end", irq_done, 1);
      chk(txd == 1'b1,        "R8 data holds bit 7 (A6)", txd, 1);
      chk(sck_o == 1'b1,      "R9 clock parked high", sck_o, 1);

      // second frame with bit 7 = 0 to show the held level
      write_byte(8'h35);
      wait_done();
      chk(txd == 1'b0, "R8 data holds bit 7 (35)", txd, 0);

      // back-to-back burst of three frames
      rise_times.delete();
      write_byte(8'h01);
      wait_empty();
      write_byte(8'hFE);
      wait_empty();
      write_byte(8'h5A);
      wait (rise_cnt >= 2*DW + DW/2 + 2);
      @(negedge clk);
      chk(tx_done == 1'b0, "R7 end flag stays 0 in burst", tx_done, 0);
      wait_done();
      chk(rise_times.size() == 3*DW, "R7 rises in burst", rise_times.size(), 3*DW);
      begin
         int bad_gap = 0;
         for (int i = 1; i < rise_times.size(); i++)
            if (rise_times[i] - rise_times[i-1] != 2*DIVH) bad_gap = rise_times[i] - rise_times[i-1];
         chk(bad_gap == 0, "R7 constant spacing across frames", bad_gap, 2*DIVH);
      end

      // receiver error blocks a start
      r0 = rise_cnt;
      rx_err = 3'b010;
      write_byte(8'hC3);
      repeat (20*DIVH) @(negedge clk);
      chk(rise_cnt == r0,     "R11 no clock while error", rise_cnt, r0);
      chk(hold_empty == 1'b0, "R11 byte kept waiting", hold_empty, 0);
      chk(txd == 1'b0,        "R11 line unchanged", txd, 0);
      rx_err = 3'b000;
      wait_done();
      chk(rise_cnt == r0 + DW, "R11 frame after error clears", rise_cnt, r0 + DW);

      // external clock mode
      ext_sck_sel = 1'b1;
      repeat (4) @(negedge clk);
      r0 = rise_cnt;
      write_byte(8'h6D);
      wait_empty();
      fork
         ext_pulses(DW);
         begin
            repeat (3*EXTH) @(negedge clk);
            chk(sck_o == 1'b1, "R9 clock pin high in external mode", sck_o, 1);
         end
      join
      repeat (6) @(negedge clk);
      chk(rise_cnt == r0 + DW, "R12 external pulses counted", rise_cnt, r0 + DW);
      chk(tx_done == 1'b1,     "R12 end flag after external frame", tx_done, 1);
      chk(txd == 1'b0,         "R12 data holds bit 7 (6D)", txd, 0);
      chk(exp_q.size() == 0,   "R5 all frames seen", exp_q.size(), 0);

      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule